// File: doc/BRIEF.md
# Programmable Raster Line Interrupt

This block raises a CPU interrupt request at a chosen scan line of a video frame. It watches the horizontal sync signal from a CRT timing controller, along with the controller's vertical character row count and the scan line inside that row. From these it forms a raster line index. An 8-bit line register can be written by the CPU through a simple write strobe and data bus. When the register holds a nonzero value, the request is raised at the start of horizontal sync on the matching line. The CPU may rewrite the register between lines to get several interrupts in one frame.

When the register holds zero, the programmed compare is switched off. A legacy periodic raster interrupt takes over. It counts horizontal sync pulses, fires on every 52nd one and restarts its count at vertical sync. The request stays pending until the CPU acknowledges it or software writes a clear strobe.

The programmed request is edge triggered on the combined condition "sync high and line matches". If horizontal sync is still high when the row and scan counters move on to the programmed line, that condition rises at the start of the line. It then rises again when sync begins at the end of the same line, so the line fires twice.

Top module: `raster_line_irq`

## Requirements
- R1: After reset `irq` is low and the line register is zero, so the legacy mechanism is the active source.
- R2: A cycle with `line_wr` high loads `line_wdata` into the line register for use from the next cycle. A rewrite between lines lets a single frame produce a request at each programmed line.
- R3: The raster index is `row_cnt*8 + scan_cnt`, truncated to its low 8 bits. The compare is equality between this index and the line register.
- R4: With a nonzero register, `irq` goes high one cycle after the first cycle in which `hsync` is high and the index matches. Holding that condition high raises no further request.
- R5: If the index changes to the programmed line while `hsync` is already high, a request is raised at once. A second request is raised when `hsync` next rises on that same line.
- R6: With a zero register no programmed compare takes place, even on line 0. `irq` is set on every 52nd rising edge of `hsync` counted since reset or since the last vertical sync.
- R7: While the register is nonzero, the legacy count produces no request.
- R8: A cycle with `vsync` high restarts the legacy count, so the next legacy request needs 52 further `hsync` rising edges.
- R9: `irq_ack` or `irq_soft_clr` drops `irq` on the next cycle. If a new request event occurs in the same cycle as the clear, the event wins and `irq` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync | input | 1 | Horizontal sync from the timing controller, active high |
| vsync | input | 1 | Vertical sync, active high; restarts the legacy count |
| row_cnt | input | ROW_W (6) | Vertical character row count |
| scan_cnt | input | SCAN_W (3) | Scan line within the character row |
| line_wr | input | 1 | Write strobe for the line register |
| line_wdata | input | LINE_W (8) | Value written to the line register |
| irq_ack | input | 1 | CPU interrupt acknowledge |
| irq_soft_clr | input | 1 | Software clear of the pending request |
| irq | output | 1 | Pending interrupt request |

## Verification
The main stimulus is a sweep. Each of several programmed values is tried against every one of the 512 row/scan combinations. Each line gets one sync pulse, and the bench predicts the request arithmetically from the index. This sorts out index arithmetic, truncation and off-by-one errors.

Holding sync high past the acknowledge separates edge triggering from level triggering. Moving onto the programmed line with sync already high brings out the double request. Long trains of sync pulses in zero mode, with a vertical sync in the middle, pin down the legacy period and its restart. The same trains with a nonzero register show the legacy source is muted. A clear that lands in the same cycle as an event shows which one wins.

// File: rtl/rli_pkg.sv
package rli_pkg;
  localparam int LINE_W        = 8;
  localparam int LEGACY_PERIOD = 52;
  typedef logic [LINE_W-1:0] line_t;
endpackage

// File: rtl/rli_line_reg.sv
module rli_line_reg #(
  parameter int LINE_W = rli_pkg::LINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [LINE_W-1:0] wdata,
  output logic [LINE_W-1:0] line_q,
  output logic              line_nz
);
  always_ff @(posedge clk) begin
    if (!rst_n)  line_q <= '0;
    else if (wr) line_q <= wdata;
  end

  assign line_nz = |line_q;

  // R2: a write lands in the register on the next cycle
  a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> line_q == $past(wdata));
endmodule

// File: rtl/rli_legacy.sv
module rli_legacy #(
  parameter int PERIOD = rli_pkg::LEGACY_PERIOD
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_rise,
  input  logic vsync,
  output logic tick
);
  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = hs_rise && !vsync && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || vsync) cnt <= '0;
    else if (hs_rise)    cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  // R6: count never leaves its period
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  // R8: vertical sync restarts the count
  a_r8_vsync_restart: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |=> cnt == '0);
endmodule

// File: rtl/rli_prog_match.sv
module rli_prog_match #(
  parameter int ROW_W  = 6,
  parameter int SCAN_W = 3,
  parameter int LINE_W = rli_pkg::LINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync,
  input  logic [ROW_W-1:0]  row_cnt,
  input  logic [SCAN_W-1:0] scan_cnt,
  input  logic [LINE_W-1:0] line_q,
  output logic              prog_evt
);
  localparam int FULL_W = ROW_W + SCAN_W;

  // row * 2^SCAN_W + scan, keeping the low LINE_W bits
  function automatic logic [LINE_W-1:0] raster_index(
    input logic [ROW_W-1:0] r, input logic [SCAN_W-1:0] s);
    logic [FULL_W-1:0] full;
    full = {r, s};
    return full[LINE_W-1:0];
  endfunction

  logic cond, cond_q;

  assign cond     = hsync && (line_q != '0) &&
                    (raster_index(row_cnt, scan_cnt) == line_q);
  assign prog_evt = cond && !cond_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cond_q <= 1'b0;
    else        cond_q <= cond;
  end

  // R4: an event needs sync high
  a_r4_needs_hsync: assert property (@(posedge clk) disable iff (!rst_n)
    prog_evt |-> hsync);
  // R4: no event two cycles running
  a_r4_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    prog_evt |=> !prog_evt);
  // R6: zero register disables the compare
  a_r6_zero_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (line_q == '0) |-> !prog_evt);
endmodule

// File: rtl/raster_line_irq.sv
module raster_line_irq #(
  parameter int ROW_W         = 6,
  parameter int SCAN_W        = 3,
  parameter int LINE_W        = rli_pkg::LINE_W,
  parameter int LEGACY_PERIOD = rli_pkg::LEGACY_PERIOD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync,
  input  logic              vsync,
  input  logic [ROW_W-1:0]  row_cnt,
  input  logic [SCAN_W-1:0] scan_cnt,
  input  logic              line_wr,
  input  logic [LINE_W-1:0] line_wdata,
  input  logic              irq_ack,
  input  logic              irq_soft_clr,
  output logic              irq
);
  logic [LINE_W-1:0] line_q;
  logic line_nz, hs_q, hs_rise, legacy_tick, prog_evt, legacy_fire, fire, clr;

  rli_line_reg #(.LINE_W(LINE_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr(line_wr), .wdata(line_wdata),
    .line_q(line_q), .line_nz(line_nz));

  always_ff @(posedge clk) begin
    if (!rst_n) hs_q <= 1'b0;
    else        hs_q <= hsync;
  end
  assign hs_rise = hsync && !hs_q;

  rli_legacy #(.PERIOD(LEGACY_PERIOD)) u_legacy (
    .clk(clk), .rst_n(rst_n), .hs_rise(hs_rise), .vsync(vsync),
    .tick(legacy_tick));

  rli_prog_match #(.ROW_W(ROW_W), .SCAN_W(SCAN_W), .LINE_W(LINE_W)) u_match (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .row_cnt(row_cnt),
    .scan_cnt(scan_cnt), .line_q(line_q), .prog_evt(prog_evt));

  assign legacy_fire = legacy_tick && !line_nz;
  assign fire        = prog_evt || legacy_fire;
  assign clr         = irq_ack || irq_soft_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= fire || (irq && !clr);
  end

  // R9: an event sets the request even against a clear
  a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> irq);
  // R9: a clear without an event drops the request
  a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !fire) |=> !irq);
  // R7: nonzero register, no match event: idle stays idle
  a_r7_legacy_muted: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && line_nz && !prog_evt) |=> !irq);
endmodule

// File: tb/tb_raster_line_irq.sv
module tb_raster_line_irq;
  localparam int CLK_P = 10;
  localparam int PER   = 52;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync = 1'b0, vsync = 1'b0;
  logic [5:0] row_cnt = '0;
  logic [2:0] scan_cnt = '0;
  logic line_wr = 1'b0;
  logic [7:0] line_wdata = '0;
  logic irq_ack = 1'b0, irq_soft_clr = 1'b0;
  logic irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  raster_line_irq dut (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .row_cnt(row_cnt), .scan_cnt(scan_cnt), .line_wr(line_wr),
    .line_wdata(line_wdata), .irq_ack(irq_ack), .irq_soft_clr(irq_soft_clr),
    .irq(irq));

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: irq=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_line(input int n);
    row_cnt  = 6'((n >> 3) & 63);
    scan_cnt = 3'(n & 7);
  endtask

  task automatic write_line(input int v);
    line_wr = 1'b1; line_wdata = 8'(v);
    tick();
    line_wr = 1'b0;
  endtask

  task automatic vpulse();
    vsync = 1'b1; tick(); vsync = 1'b0; tick();
  endtask

  // one sync pulse on the current line; check after the rising edge
  task automatic legacy_pulse(input string req, input logic exp);
    hsync = 1'b1; tick();
    chk(req, irq, exp);
    hsync = 1'b0; irq_ack = irq; tick();
    irq_ack = 1'b0; tick();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1", irq, 1'b0);

    // R1/R6: no write since reset, line 0 current; legacy every 52nd rise
    set_line(0);
    for (int k = 1; k <= 110; k++)
      legacy_pulse((k == 1) ? "R1" : "R6", (k % PER) == 0);

    // R8: vsync part-way restarts the count
    vpulse();
    for (int k = 1; k <= 30; k++) legacy_pulse("R8", 1'b0);
    vpulse();
    for (int k = 1; k <= PER; k++) legacy_pulse("R8", k == PER);

    // R7: nonzero register mutes legacy
    write_line(5);
    vpulse();
    set_line(0);
    for (int k = 1; k <= 60; k++) legacy_pulse("R7", 1'b0);

    // R2/R3/R4: sweep all 512 row/scan pairs per programmed value
    foreach (sweep_vals[i]) begin
      write_line(sweep_vals[i]);
      for (int n = 0; n < 512; n++) begin
        logic e;
        e = ((n & 255) == sweep_vals[i]);
        set_line(n); hsync = 1'b0; tick();
        hsync = 1'b1; tick();
        chk((n > 255) ? "R3" : "R2", irq, e);
        irq_ack = 1'b1; tick();
        irq_ack = 1'b0; hsync = 1'b0;
        chk("R4", irq, 1'b0);
      end
    end

    // R5: sync still high when the line becomes the programmed one
    write_line(10);
    set_line(9); hsync = 1'b1; tick();
    chk("R5", irq, 1'b0);
    set_line(10); tick();
    chk("R5", irq, 1'b1);
    irq_ack = 1'b1; tick();
    irq_ack = 1'b0; hsync = 1'b0; tick();
    chk("R5", irq, 1'b0);
    tick(); tick();
    hsync = 1'b1; tick();
    chk("R5", irq, 1'b1);
    hsync = 1'b0; irq_soft_clr = 1'b1; tick();
    irq_soft_clr = 1'b0;
    chk("R9", irq, 1'b0);

    // R9: clear in the same cycle as an event; event wins
    set_line(20); write_line(20);
    hsync = 1'b1; irq_ack = 1'b1; tick();
    irq_ack = 1'b0;
    chk("R9", irq, 1'b1);
    tick();
    chk("R9", irq, 1'b1);
    hsync = 1'b0; irq_soft_clr = 1'b1; tick();
    irq_soft_clr = 1'b0;
    chk("R9", irq, 1'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  int sweep_vals[4] = '{1, 44, 200, 255};

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, done=%0b expected 1", done);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule